// File: doc/BRIEF.md
# Double-Bank Sample Capture Buffer

This block sits on a sensing node between a converter that delivers one 16-bit sample at a time and a transmit path that drains stored samples in bursts. It holds two equal memory banks. One bank takes incoming samples while the other is read out by the transmit side, and both go on at once.

When the bank being filled takes its last word, the block marks it ready. If the other bank has already been read out, the roles swap at once. If the other bank still holds unread data, nothing is ever written over it. Samples that arrive while both banks are full are discarded, and a sticky overrun flag records the loss. Once the older bank has been drained, the next sample opens that bank at address 0.

The transmit side pulses a read strobe while the ready flag is high. Each strobe returns the next stored word one cycle later. Words come back in the order they were written, the oldest bank first.

Top module: `pingpong_sample_buf`

## Requirements
- R1: After a cycle with `rst` high, `wr_bank_sel` is 0, and `bank_ready`, `overrun` and `rd_data_valid` are 0.
- R2: Every sample offered with `smp_valid` high and not discarded is stored at the next address of the fill bank. Its 16 bits come back unchanged, in write order across both banks.
- R3: On the clock edge that stores the last word (word DEPTH) of a bank, that bank becomes full, and `bank_ready` is high after that edge.
- R4: If the other bank is empty when a bank completes, `wr_bank_sel` toggles on the same edge, and the next sample goes to address 0 of the other bank.
- R5: If the other bank still holds unread data when a bank completes, `wr_bank_sel` holds. Each later sample is discarded and `overrun` goes high, until the other bank has been drained. The first sample after the drain is stored at address 0 of the drained bank, and `wr_bank_sel` toggles.
- R6: `overrun` stays high until reset.
- R7: A `rd_en` pulse while `bank_ready` is high returns one word on `rd_data`, with `rd_data_valid` high in the next cycle. Reading starts at address 0 and advances by one word per pulse.
- R8: A `rd_en` pulse while `bank_ready` is low is ignored: `rd_data_valid` stays low and the read address does not move.
- R9: After the last word of a bank is read, `bank_ready` falls. It stays high if the other bank is already full, and reading then continues with that bank from address 0.
- R10: A bank that is full is never written until it has been completely read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_data | input | 16 | Sample value |
| rd_en | input | 1 | Read strobe from the transmit side |
| rd_data | output | 16 | Word read out |
| rd_data_valid | output | 1 | `rd_data` holds a word read by the previous strobe |
| bank_ready | output | 1 | A full bank is waiting to be read |
| overrun | output | 1 | Sticky: a sample was discarded |
| wr_bank_sel | output | 1 | Index of the bank currently being filled |

## Verification
A sample strobe is taken at one clock edge. Its effect on `bank_ready`, `wr_bank_sel` and `overrun` is visible right after that edge, so the bench checks these flags at the falling edge that follows the strobe. A read strobe produces `rd_data` and `rd_data_valid` after one edge. The monitor samples at every falling edge and compares any valid word against the head of the expected queue, so a word that arrives in the wrong cycle or out of order shows up as a mismatch. The driver pushes a sample into the queue only when the requirements say it is stored, so discarded samples must never come out of the buffer.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned PP_BANKS = 2;
  typedef logic [0:0] bank_t;

  function automatic bank_t other_bank(input bank_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/pp_bank_mem.sv
module pp_bank_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_bank_status.sv
module pp_bank_status
  import pp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                fill_done,
  input  bank_t               fill_bank,
  input  logic                drain_done,
  input  bank_t               drain_bank,
  output logic [PP_BANKS-1:0] full_q
);
  for (genvar b = 0; b < PP_BANKS; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        full_q[b] <= 1'b0;
      else if (fill_done && fill_bank == bank_t'(b))
        full_q[b] <= 1'b1;
      else if (drain_done && drain_bank == bank_t'(b))
        full_q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl
  import pp_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [PP_BANKS-1:0] full_q,
  output logic                wr_en,
  output bank_t               wr_bank,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic                fill_done,
  output bank_t               wr_sel_q,
  output logic                overrun_q
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  bank_t             sel_d;
  logic              drop;
  bank_t             oth;

  always_comb begin
    oth       = other_bank(wr_sel_q);
    wr_en     = 1'b0;
    wr_bank   = wr_sel_q;
    wr_addr   = addr_q;
    fill_done = 1'b0;
    drop      = 1'b0;
    sel_d     = wr_sel_q;
    addr_d    = addr_q;
    if (smp_valid) begin
      if (!full_q[wr_sel_q]) begin
        wr_en = 1'b1;
        if (addr_q == LAST) begin
          fill_done = 1'b1;
          addr_d    = '0;
          if (!full_q[oth]) sel_d = oth;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end else if (!full_q[oth]) begin
        // late swap: older bank has just been drained
        wr_en   = 1'b1;
        wr_bank = oth;
        wr_addr = '0;
        sel_d   = oth;
        addr_d  = ADDR_W'(1);
      end else begin
        drop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sel_q  <= '0;
      addr_q    <= '0;
      overrun_q <= 1'b0;
    end else begin
      wr_sel_q <= sel_d;
      addr_q   <= addr_d;
      if (drop) overrun_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl
  import pp_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [PP_BANKS-1:0] full_q,
  output logic                rd_fire,
  output bank_t               rd_sel_q,
  output logic [ADDR_W-1:0]   rd_addr_q,
  output logic                drain_done,
  output logic                rd_valid_q,
  output bank_t               rd_bank_q1
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  assign rd_fire    = rd_en && full_q[rd_sel_q];
  assign drain_done = rd_fire && (rd_addr_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q   <= '0;
      rd_addr_q  <= '0;
      rd_valid_q <= 1'b0;
      rd_bank_q1 <= '0;
    end else begin
      rd_valid_q <= rd_fire;
      rd_bank_q1 <= rd_sel_q;
      if (rd_fire) begin
        if (drain_done) begin
          rd_addr_q <= '0;
          rd_sel_q  <= other_bank(rd_sel_q);
        end else begin
          rd_addr_q <= rd_addr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pingpong_sample_buf.sv
module pingpong_sample_buf
  import pp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_valid,
  output logic              bank_ready,
  output logic              overrun,
  output logic              wr_bank_sel
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic [PP_BANKS-1:0] full_q;
  logic                wr_en, fill_done, overrun_q;
  bank_t               wr_bank, wr_sel_q;
  logic [ADDR_W-1:0]   wr_addr;
  logic                rd_fire, drain_done, rd_valid_q;
  bank_t               rd_sel_q, rd_bank_q1;
  logic [ADDR_W-1:0]   rd_addr_q;
  logic [DATA_W-1:0]   bank_rdata [PP_BANKS];

  pp_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .full_q(full_q),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .fill_done(fill_done), .wr_sel_q(wr_sel_q), .overrun_q(overrun_q)
  );

  pp_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .full_q(full_q),
    .rd_fire(rd_fire), .rd_sel_q(rd_sel_q), .rd_addr_q(rd_addr_q),
    .drain_done(drain_done), .rd_valid_q(rd_valid_q), .rd_bank_q1(rd_bank_q1)
  );

  pp_bank_status u_stat (
    .clk(clk), .rst(rst),
    .fill_done(fill_done), .fill_bank(wr_bank),
    .drain_done(drain_done), .drain_bank(rd_sel_q),
    .full_q(full_q)
  );

  for (genvar b = 0; b < PP_BANKS; b++) begin : g_bank
    pp_bank_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk),
      .we(wr_en && wr_bank == bank_t'(b)),
      .waddr(wr_addr),
      .wdata(smp_data),
      .re(rd_fire && rd_sel_q == bank_t'(b)),
      .raddr(rd_addr_q),
      .rdata(bank_rdata[b])
    );
  end

  // all outputs come straight from flops or a mux of flops
  assign rd_data       = bank_rdata[rd_bank_q1];
  assign rd_data_valid = rd_valid_q;
  assign bank_ready    = full_q[rd_sel_q];
  assign overrun       = overrun_q;
  assign wr_bank_sel   = wr_sel_q;
endmodule

// File: rtl/pp_sample_buf_chk.sv
module pp_sample_buf_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_valid,
  input logic       rd_en,
  input logic       rd_data_valid,
  input logic       bank_ready,
  input logic       overrun,
  input logic       wr_bank_sel,
  input logic       wr_en,
  input logic [0:0] wr_bank,
  input logic       fill_done,
  input logic [1:0] full_q
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bank_ready && !overrun && !rd_data_valid && !wr_bank_sel));

  a_r3_ready_after_fill: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> (bank_ready || $past(full_q) == 2'b11));

  a_r5_drop_flags_overrun: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !wr_en) |=> overrun);

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r7_read_returns: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bank_ready) |=> rd_data_valid);

  a_r8_idle_read_ignored: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !bank_ready) |=> !rd_data_valid);

  a_r10_no_write_to_full: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full_q[wr_bank]);
endmodule

bind pingpong_sample_buf pp_sample_buf_chk chk_i (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .rd_en(rd_en),
  .rd_data_valid(rd_data_valid), .bank_ready(bank_ready), .overrun(overrun),
  .wr_bank_sel(wr_bank_sel), .wr_en(wr_en), .wr_bank(wr_bank),
  .fill_done(fill_done), .full_q(full_q)
);

// File: tb/pingpong_sample_buf_tb_top.sv
module pingpong_sample_buf_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH      = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_data_valid, bank_ready, overrun, wr_bank_sel;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] exp_q[$];
  int          seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_sample_buf dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_data_valid(rd_data_valid),
    .bank_ready(bank_ready), .overrun(overrun), .wr_bank_sel(wr_bank_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: one sample per cycle, expected queue updated only if stored
  task automatic send(input bit stored);
    logic [15:0] v;
    v = 16'(seq * 16'h9e37 + 16'h1234);
    seq++;
    smp_valid = 1'b1;
    smp_data  = v;
    if (stored) exp_q.push_back(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic send_n(input int n, input bit stored);
    for (int i = 0; i < n; i++) send(stored);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
  endtask

  // monitor: compare every valid word with the head of the queue (R2, R7)
  always @(negedge clk) begin
    if (!rst && rd_data_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected word", int'(rd_data), -1);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rd_data === e, "R2/R7 read order", int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(wr_bank_sel == 0, "R1 wr_bank_sel", wr_bank_sel, 0);
    check(bank_ready == 0, "R1 bank_ready", bank_ready, 0);
    check(overrun == 0, "R1 overrun", overrun, 0);
    check(rd_data_valid == 0, "R1 rd_data_valid", rd_data_valid, 0);

    // R8 read while nothing ready
    read_n(2);
    check(rd_data_valid == 0, "R8 idle read", rd_data_valid, 0);

    // R3, R4 fill bank 0
    send_n(DEPTH - 1, 1'b1);
    check(bank_ready == 0, "R3 not ready early", bank_ready, 0);
    send(1'b1);
    check(bank_ready == 1, "R3 ready after fill", bank_ready, 1);
    check(wr_bank_sel == 1, "R4 swap to bank1", wr_bank_sel, 1);

    // drain bank 0 while filling bank 1
    fork
      read_n(DEPTH);
      send_n(100, 1'b1);
    join
    @(negedge clk);
    check(bank_ready == 0, "R9 ready falls", bank_ready, 0);
    check(wr_bank_sel == 1, "R4 still bank1", wr_bank_sel, 1);

    // fill bank 1 then bank 0 without reading
    send_n(DEPTH - 100, 1'b1);
    check(wr_bank_sel == 0, "R4 swap to bank0", wr_bank_sel, 0);
    check(bank_ready == 1, "R3 bank1 ready", bank_ready, 1);
    send_n(DEPTH, 1'b1);
    check(wr_bank_sel == 0, "R5 hold on full", wr_bank_sel, 0);
    check(overrun == 0, "R5 no overrun yet", overrun, 0);
    send_n(3, 1'b0);
    check(overrun == 1, "R5 overrun set", overrun, 1);

    // drain bank 1; bank 0 must still hold its own data (R10)
    read_n(DEPTH);
    @(negedge clk);
    check(bank_ready == 1, "R9 stays ready", bank_ready, 1);
    send(1'b1);
    check(wr_bank_sel == 1, "R5 late swap", wr_bank_sel, 1);
    read_n(DEPTH);
    @(negedge clk);
    check(bank_ready == 0, "R9 ready falls again", bank_ready, 0);
    check(overrun == 1, "R6 sticky", overrun, 1);
    check(exp_q.size() == 1, "R10 queue level", exp_q.size(), 1);

    // late-swapped bank starts at address 0
    send_n(DEPTH - 1, 1'b1);
    check(bank_ready == 1, "R5 bank1 ready", bank_ready, 1);
    read_n(DEPTH);
    @(negedge clk);
    check(exp_q.size() == 0, "R2 all words read", exp_q.size(), 0);

    // R1 reset clears the sticky flag
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(overrun == 0, "R1 overrun cleared", overrun, 0);
    check(bank_ready == 0, "R1 ready cleared", bank_ready, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule